// File: doc/BRIEF.md
# Address translation fault reporter

This block sits between a processor's memory request (data load, data store or instruction fetch) and a small translation lookup. For each valid request it decides whether translation applies. With translation off, the address maps to itself with full read, write and execute rights. With translation on and a lookup hit, the physical address is formed from the lookup entry's physical page base and the request's offset inside the entry's virtual page. The permissions come from the entry.

When the lookup reports a miss or a protection failure, the block records the complete faulting virtual address and a fault status code. It then holds a fault request toward the exception logic until that logic acknowledges it. A second fault that arrives while one is still pending is not recoverable. It raises a sticky fatal flag and leaves the first fault's record in place. All outputs are registered and change on the clock edge that samples the request.

Top module: `xlat_fault_unit`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: rsp_valid, rsp_xlated, rsp_paddr, rsp_perm, fault_req, fault_addr, fault_status, fatal_recursive and lk_internal_err.
- R2: Translation is active only when cfg_xlat_fitted and msr_vmode are both 1. Otherwise a valid request yields, on the next edge, rsp_valid=1, rsp_xlated=0, rsp_paddr equal to req_vaddr and rsp_perm=3'b111 ({read,write,execute}). The lookup result is ignored.
- R3: When cfg_full_regs=1 and cfg_reg_xlat_bit=0, the unit is treated as absent and requests are bypassed as in R2, even with cfg_xlat_fitted=1 and msr_vmode=1.
- R4: When active and lk_err=0 (hit), the next edge gives rsp_valid=1, rsp_xlated=1, rsp_paddr = page-aligned lk_pbase + (req_vaddr − page-aligned lk_vbase), and rsp_perm = lk_perm.
- R5: When active and lk_err is 1 (miss) or 2 (protection), no response is given. fault_addr takes the full req_vaddr, and fault_req is 1 from the next edge onward.
- R6: req_kind is encoded as 0 load, 1 store, 2 fetch; 3 counts as a data access. The low bits of fault_status are 17 for a protection fault on a fetch, 16 for one on a data access, 19 for a miss on a fetch and 18 for a miss on a data access.
- R7: fault_status bit 10 is 1 exactly when the faulting access is a store.
- R8: A fault while fault_req is 1 and fault_ack is 0 sets fatal_recursive. The flag stays set until reset, and fault_addr and fault_status keep the first fault.
- R9: fault_ack clears fault_req at the next edge. A new fault in the same cycle as fault_ack is recorded as a fresh fault, and fatal_recursive is not set.
- R10: When active, lk_err=3 gives no response and no fault. It sets lk_internal_err, which stays set until reset.
- R11: With req_valid=0, rsp_valid is 0 at the next edge, and fault_addr, fault_status and fault_req do not change apart from an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_vaddr | input | ADDR_W | Virtual request address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| cfg_xlat_fitted | input | 1 | Translation unit built in |
| cfg_full_regs | input | 1 | Full configuration register set implemented |
| cfg_reg_xlat_bit | input | 1 | Translation-present bit of that register set |
| msr_vmode | input | 1 | Virtual-mode bit of the machine status |
| lk_err | input | 2 | Lookup result: 0 hit, 1 miss, 2 protection, 3 invalid |
| lk_vbase | input | ADDR_W | Virtual page base of the hit entry |
| lk_pbase | input | ADDR_W | Physical page base of the hit entry |
| lk_perm | input | 3 | Entry rights {read,write,execute} |
| fault_ack | input | 1 | Exception logic has taken the pending fault |
| rsp_valid | output | 1 | Translated or bypassed address valid |
| rsp_xlated | output | 1 | Response came through translation |
| rsp_paddr | output | ADDR_W | Physical address |
| rsp_perm | output | 3 | Granted rights {read,write,execute} |
| fault_req | output | 1 | Translation fault pending |
| fault_addr | output | ADDR_W | Faulting virtual address |
| fault_status | output | ST_W | Fault status code |
| fatal_recursive | output | 1 | Sticky: fault while one pending |
| lk_internal_err | output | 1 | Sticky: invalid lookup result seen |

## Verification
The bench uses the defaults: 32-bit addresses, a 4 KiB page and a 16-bit status field. Bit 10 of the status therefore sits above the class code, and offsets up to 0xFFF can be tested at both ends of a page. With these values the bench can reach page bases near the top of the address space, offsets at the last word of a page and every combination of fault class and access kind. It can also reach the same-cycle acknowledge and new-fault case, which separates a recursive fault from a back-to-back fault.

// File: rtl/xlat_pkg.sv
// Package: shared encodings for the address translation fault reporter.
// Assumes the status field is at least 11 bits wide so the store flag fits.
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        LK_HIT  = 2'd0,
        LK_MISS = 2'd1,
        LK_PROT = 2'd2,
        LK_BAD  = 2'd3
    } lk_err_e;

    localparam int CODE_W    = 11;
    localparam int STORE_BIT = 10;

    // Build the status code from the fault class and the access kind.
    function automatic logic [CODE_W-1:0] fault_code(input logic is_miss,
                                                     input acc_kind_e kind);
        logic [CODE_W-1:0] c;
        c = 11'd16;
        c[1] = is_miss;
        c[0] = (kind == ACC_FETCH);
        c[STORE_BIT] = (kind == ACC_STORE);
        return c;
    endfunction

endpackage

// File: rtl/xlat_mode_sel.sv
// Module: decides whether translation applies to the current request.
// Assumes all configuration inputs are static or synchronous to clk.
module xlat_mode_sel (
    input  logic cfg_xlat_fitted,
    input  logic cfg_full_regs,
    input  logic cfg_reg_xlat_bit,
    input  logic msr_vmode,
    output logic xlat_active
);
    logic unit_present;

    // Unit is present when built in and not disabled by the register set.
    always_comb begin
        unit_present = cfg_xlat_fitted && !(cfg_full_regs && !cfg_reg_xlat_bit);
        xlat_active  = unit_present && msr_vmode;
    end
endmodule

// File: rtl/xlat_addr_calc.sv
// Module: forms the physical address and rights for bypass or hit.
// Assumes the request address lies in the entry's virtual page on a hit;
// entry bases are masked to the page boundary here.
module xlat_addr_calc #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              xlat_active,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] lk_vbase,
    input  logic [ADDR_W-1:0] lk_pbase,
    input  logic [2:0]        lk_perm,
    output logic [ADDR_W-1:0] paddr,
    output logic [2:0]        perm
);
    localparam int PAGE_SH = $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0] page_mask;
    logic [ADDR_W-1:0] vpage;
    logic [ADDR_W-1:0] ppage;

    generate
        if (PAGE_SH == 0) begin : g_nomask
            // Byte pages: every address is its own page base.
            assign page_mask = '1;
        end else begin : g_mask
            // Clear the in-page offset bits.
            assign page_mask = {{(ADDR_W-PAGE_SH){1'b1}}, {PAGE_SH{1'b0}}};
        end
    endgenerate

    // Select identity mapping or base-plus-offset translation.
    always_comb begin
        vpage = lk_vbase & page_mask;
        ppage = lk_pbase & page_mask;
        if (xlat_active) begin
            paddr = ppage + (req_vaddr - vpage);
            perm  = lk_perm;
        end else begin
            paddr = req_vaddr;
            perm  = 3'b111;
        end
    end
endmodule

// File: rtl/xlat_fault_capture.sv
// Module: records translation faults and holds the pending request.
// Assumes fault_ack is a single-cycle pulse from the exception logic.
module xlat_fault_capture #(
    parameter int ADDR_W = 32,
    parameter int ST_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              xlat_active,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        lk_err,
    input  logic              fault_ack,
    output logic              fault_req,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [ST_W-1:0]   fault_status,
    output logic              fatal_recursive,
    output logic              lk_internal_err
);
    import xlat_pkg::*;

    logic                 new_fault;
    logic                 bad_lookup;
    logic                 fresh_slot;
    logic [CODE_W-1:0]    code;

    // Classify the current lookup outcome.
    always_comb begin
        new_fault  = req_valid && xlat_active &&
                     (lk_err == LK_MISS || lk_err == LK_PROT);
        bad_lookup = req_valid && xlat_active && (lk_err == LK_BAD);
        fresh_slot = !fault_req || fault_ack;
        code       = fault_code(lk_err == LK_MISS, acc_kind_e'(req_kind));
    end

    // Fault record, pending flag and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_req       <= 1'b0;
            fault_addr      <= '0;
            fault_status    <= '0;
            fatal_recursive <= 1'b0;
            lk_internal_err <= 1'b0;
        end else begin
            if (new_fault && fresh_slot) begin
                fault_addr   <= req_vaddr;
                fault_status <= ST_W'(code);
            end
            if (new_fault) begin
                fault_req <= 1'b1;
            end else if (fault_ack) begin
                fault_req <= 1'b0;
            end
            if (new_fault && !fresh_slot) begin
                fatal_recursive <= 1'b1;
            end
            if (bad_lookup) begin
                lk_internal_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_fault_unit.sv
// Module: top of the address translation fault reporter.
// Registers the address response; faults are held in xlat_fault_capture.
// Assumes ST_W >= 11 and PAGE_BYTES a power of two.
module xlat_fault_unit #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int ST_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              cfg_xlat_fitted,
    input  logic              cfg_full_regs,
    input  logic              cfg_reg_xlat_bit,
    input  logic              msr_vmode,
    input  logic [1:0]        lk_err,
    input  logic [ADDR_W-1:0] lk_vbase,
    input  logic [ADDR_W-1:0] lk_pbase,
    input  logic [2:0]        lk_perm,
    input  logic              fault_ack,
    output logic              rsp_valid,
    output logic              rsp_xlated,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_perm,
    output logic              fault_req,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [ST_W-1:0]   fault_status,
    output logic              fatal_recursive,
    output logic              lk_internal_err
);
    import xlat_pkg::*;

    logic              xlat_active;
    logic [ADDR_W-1:0] calc_paddr;
    logic [2:0]        calc_perm;
    logic              give_rsp;

    xlat_mode_sel mode_i (
        .cfg_xlat_fitted (cfg_xlat_fitted),
        .cfg_full_regs   (cfg_full_regs),
        .cfg_reg_xlat_bit(cfg_reg_xlat_bit),
        .msr_vmode       (msr_vmode),
        .xlat_active     (xlat_active)
    );

    xlat_addr_calc #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) calc_i (
        .xlat_active(xlat_active),
        .req_vaddr  (req_vaddr),
        .lk_vbase   (lk_vbase),
        .lk_pbase   (lk_pbase),
        .lk_perm    (lk_perm),
        .paddr      (calc_paddr),
        .perm       (calc_perm)
    );

    xlat_fault_capture #(.ADDR_W(ADDR_W), .ST_W(ST_W)) cap_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .xlat_active    (xlat_active),
        .req_vaddr      (req_vaddr),
        .req_kind       (req_kind),
        .lk_err         (lk_err),
        .fault_ack      (fault_ack),
        .fault_req      (fault_req),
        .fault_addr     (fault_addr),
        .fault_status   (fault_status),
        .fatal_recursive(fatal_recursive),
        .lk_internal_err(lk_internal_err)
    );

    // A response exists for bypass or for a hit.
    always_comb begin
        give_rsp = req_valid && (!xlat_active || lk_err == LK_HIT);
    end

    // Register the address response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_xlated <= 1'b0;
            rsp_paddr  <= '0;
            rsp_perm   <= '0;
        end else begin
            rsp_valid <= give_rsp;
            if (give_rsp) begin
                rsp_xlated <= xlat_active;
                rsp_paddr  <= calc_paddr;
                rsp_perm   <= calc_perm;
            end
        end
    end
endmodule

// File: rtl/xlat_fault_unit_chk.sv
// Module: temporal checks on the fault reporter's ports, bound to the top.
module xlat_fault_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int ST_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              fault_ack,
    input logic              rsp_valid,
    input logic              rsp_xlated,
    input logic [2:0]        rsp_perm,
    input logic              fault_req,
    input logic [ADDR_W-1:0] fault_addr,
    input logic [ST_W-1:0]   fault_status,
    input logic              fatal_recursive,
    input logic              lk_internal_err
);
    // R2
    bypass_full_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_xlated) |-> rsp_perm == 3'b111);
    // R5
    fault_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_req) |-> !rsp_valid);
    // R6
    status_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> (fault_status[4] && fault_status[3:2] == 2'b00));
    // R8
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_recursive |=> fatal_recursive);
    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ack && !req_valid) |=> !fault_req);
    // R10
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_internal_err |=> lk_internal_err);
    // R11
    idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R11
    idle_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(fault_addr) && $stable(fault_status)));
endmodule

bind xlat_fault_unit xlat_fault_unit_chk #(.ADDR_W(ADDR_W), .ST_W(ST_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .fault_ack      (fault_ack),
    .rsp_valid      (rsp_valid),
    .rsp_xlated     (rsp_xlated),
    .rsp_perm       (rsp_perm),
    .fault_req      (fault_req),
    .fault_addr     (fault_addr),
    .fault_status   (fault_status),
    .fatal_recursive(fatal_recursive),
    .lk_internal_err(lk_internal_err)
);

// File: tb/xlat_fault_unit_tb.sv
module xlat_fault_unit_tb_top;
    localparam int AW = 32;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_vaddr = '0;
    logic [1:0]    req_kind = '0;
    logic          cfg_xlat_fitted = 1'b0;
    logic          cfg_full_regs = 1'b0;
    logic          cfg_reg_xlat_bit = 1'b0;
    logic          msr_vmode = 1'b0;
    logic [1:0]    lk_err = '0;
    logic [AW-1:0] lk_vbase = '0;
    logic [AW-1:0] lk_pbase = '0;
    logic [2:0]    lk_perm = '0;
    logic          fault_ack = 1'b0;
    logic          rsp_valid, rsp_xlated, fault_req, fatal_recursive, lk_internal_err;
    logic [AW-1:0] rsp_paddr, fault_addr;
    logic [2:0]    rsp_perm;
    logic [SW-1:0] fault_status;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xlat_fault_unit dut_i (.*);

    typedef struct packed {
        logic [3:0]  cfg;      // {fitted, full_regs, reg_bit, vmode}
        logic [1:0]  kind;
        logic [1:0]  err;
        logic [31:0] vaddr;
        logic [31:0] vbase;
        logic [31:0] pbase;
        logic [2:0]  perm;
        logic        e_fault;  // 1: fault expected, else response
        logic        e_xl;
        logic [31:0] e_addr;   // paddr, or fault address
        logic [2:0]  e_perm;
        logic [15:0] e_stat;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R2 translation off by vmode
        '{4'b1000, 2'd0, 2'd1, 32'h1234_5678, 32'h0, 32'h0, 3'b000, 1'b0, 1'b0, 32'h1234_5678, 3'b111, 16'h0},
        // R2 unit not fitted
        '{4'b0001, 2'd1, 2'd2, 32'h0000_0ABC, 32'h0, 32'h0, 3'b000, 1'b0, 1'b0, 32'h0000_0ABC, 3'b111, 16'h0},
        // R3 register set says absent
        '{4'b1101, 2'd2, 2'd1, 32'hC000_0010, 32'h0, 32'h0, 3'b000, 1'b0, 1'b0, 32'hC000_0010, 3'b111, 16'h0},
        // R4 hit with full register set present
        '{4'b1111, 2'd0, 2'd0, 32'h4000_1234, 32'h4000_1000, 32'h8000_5000, 3'b101, 1'b0, 1'b1, 32'h8000_5234, 3'b101, 16'h0},
        // R4 hit at last word of page, base with offset bits
        '{4'b1001, 2'd1, 2'd0, 32'h0010_2FFC, 32'h0010_2ABC, 32'h0FFF_F123, 3'b011, 1'b0, 1'b1, 32'h0FFF_FFFC, 3'b011, 16'h0},
        // R6 protection fetch 17
        '{4'b1001, 2'd2, 2'd2, 32'hDEAD_BEEF, 32'h0, 32'h0, 3'b000, 1'b1, 1'b0, 32'hDEAD_BEEF, 3'b000, 16'd17},
        // R6 protection load 16
        '{4'b1001, 2'd0, 2'd2, 32'h0000_1001, 32'h0, 32'h0, 3'b000, 1'b1, 1'b0, 32'h0000_1001, 3'b000, 16'd16},
        // R6 miss fetch 19
        '{4'b1001, 2'd2, 2'd1, 32'hFFFF_F000, 32'h0, 32'h0, 3'b000, 1'b1, 1'b0, 32'hFFFF_F000, 3'b000, 16'd19},
        // R6 miss load 18
        '{4'b1001, 2'd0, 2'd1, 32'h7654_3210, 32'h0, 32'h0, 3'b000, 1'b1, 1'b0, 32'h7654_3210, 3'b000, 16'd18},
        // R7 miss store
        '{4'b1001, 2'd1, 2'd1, 32'h2000_0004, 32'h0, 32'h0, 3'b000, 1'b1, 1'b0, 32'h2000_0004, 3'b000, 16'h0412},
        // R7 protection store
        '{4'b1001, 2'd1, 2'd2, 32'h3000_0FFF, 32'h0, 32'h0, 3'b000, 1'b1, 1'b0, 32'h3000_0FFF, 3'b000, 16'h0410}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [3:0] cfg, input logic [1:0] kind, input logic [1:0] err,
                         input logic [31:0] va, input logic ack);
        @(negedge clk);
        {cfg_xlat_fitted, cfg_full_regs, cfg_reg_xlat_bit, msr_vmode} = cfg;
        req_valid = 1'b1;
        req_kind  = kind;
        lk_err    = err;
        req_vaddr = va;
        fault_ack = ack;
        tick();
        @(negedge clk);
        req_valid = 1'b0;
        fault_ack = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        fault_ack = 1'b1;
        tick();
        @(negedge clk);
        fault_ack = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk(!rsp_valid && !rsp_xlated && rsp_paddr == 0 && rsp_perm == 0, "R1 rsp", {rsp_valid, rsp_paddr}, 0);
        chk(!fault_req && fault_addr == 0 && fault_status == 0 && !fatal_recursive && !lk_internal_err,
            "R1 fault", {fault_req, fault_status, fatal_recursive, lk_internal_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cfg_xlat_fitted, cfg_full_regs, cfg_reg_xlat_bit, msr_vmode} = VECS[i].cfg;
            req_valid = 1'b1;
            req_kind  = VECS[i].kind;
            lk_err    = VECS[i].err;
            req_vaddr = VECS[i].vaddr;
            lk_vbase  = VECS[i].vbase;
            lk_pbase  = VECS[i].pbase;
            lk_perm   = VECS[i].perm;
            tick();
            if (VECS[i].e_fault) begin
                chk(!rsp_valid && fault_req && fault_addr == VECS[i].e_addr, $sformatf("R5 vec%0d", i),
                    {rsp_valid, fault_req, fault_addr}, {2'b01, VECS[i].e_addr});
                chk(fault_status == VECS[i].e_stat, $sformatf("R6/R7 vec%0d", i), fault_status, VECS[i].e_stat);
            end else begin
                chk(rsp_valid && rsp_xlated == VECS[i].e_xl && rsp_paddr == VECS[i].e_addr
                    && rsp_perm == VECS[i].e_perm, $sformatf("R2/R3/R4 vec%0d", i),
                    {rsp_valid, rsp_xlated, rsp_perm, rsp_paddr},
                    {1'b1, VECS[i].e_xl, VECS[i].e_perm, VECS[i].e_addr});
            end
            @(negedge clk);
            req_valid = 1'b0;
            if (VECS[i].e_fault) begin
                fault_ack = 1'b1;
                tick();
                chk(!fault_req && !fatal_recursive, "R9 ack clears", {fault_req, fatal_recursive}, 0);
                @(negedge clk);
                fault_ack = 1'b0;
            end
        end

        // R11: faulting lookup values with req_valid low change nothing
        @(negedge clk);
        {cfg_xlat_fitted, cfg_full_regs, cfg_reg_xlat_bit, msr_vmode} = 4'b1001;
        lk_err = 2'd1;
        req_kind = 2'd1;
        req_vaddr = 32'h5555_0000;
        tick();
        chk(!rsp_valid && !fault_req && fault_addr == 32'h3000_0FFF && fault_status == 16'h0410,
            "R11 idle", {rsp_valid, fault_req, fault_addr}, {2'b00, 32'h3000_0FFF});

        // R9: acknowledge and new fault in the same cycle
        drive(4'b1001, 2'd0, 2'd1, 32'hA000_0000, 1'b0);
        drive(4'b1001, 2'd2, 2'd2, 32'hB000_0008, 1'b1);
        chk(fault_req && !fatal_recursive && fault_addr == 32'hB000_0008 && fault_status == 16'd17,
            "R9 ack+new", {fault_req, fatal_recursive, fault_addr, fault_status},
            {2'b10, 32'hB000_0008, 16'd17});
        ack_pulse();

        // R10: invalid lookup result
        drive(4'b1001, 2'd0, 2'd3, 32'hC0DE_0000, 1'b0);
        chk(!rsp_valid && !fault_req && lk_internal_err, "R10 bad lookup",
            {rsp_valid, fault_req, lk_internal_err}, 3'b001);
        tick();
        chk(lk_internal_err, "R10 sticky", lk_internal_err, 1);

        // R8: recursive fault keeps the first record
        drive(4'b1001, 2'd1, 2'd1, 32'h1111_1000, 1'b0);
        drive(4'b1001, 2'd2, 2'd2, 32'h2222_2000, 1'b0);
        chk(fatal_recursive && fault_addr == 32'h1111_1000 && fault_status == 16'h0412,
            "R8 recursive", {fatal_recursive, fault_addr, fault_status}, {1'b1, 32'h1111_1000, 16'h0412});
        ack_pulse();
        chk(fatal_recursive && !fault_req, "R8 sticky", {fatal_recursive, fault_req}, 2'b10);

        // R1: reset clears sticky flags
        @(negedge clk);
        rst_n = 1'b0;
        tick();
        chk(!fatal_recursive && !lk_internal_err && !fault_req && fault_addr == 0,
            "R1 re-reset", {fatal_recursive, lk_internal_err, fault_req}, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule